// File: doc/BRIEF.md
# External Interrupt Trigger Conditioner

This block takes a small set of asynchronous external interrupt pins (six by default) and turns each one into a clean, maskable interrupt request. Every pin is brought into the clock domain through a two-stage synchroniser. It is then judged against a per-line trigger mode: active-high level, active-low level, rising edge, falling edge or any edge. In the edge modes a detected transition sets a sticky event flag, which stays set until software acknowledges it with a write-1 clear. In the level modes the request simply tracks the synchronised pin.

Software reaches the configuration through a plain register port. Each 32-bit control word serves four lines, where the slot of a line is its index modulo 4. Lines 0 to 3 live in word 0 and lines 4 and 5 in word 1. A build-time parameter chooses where the requests go. They can be driven as separate interrupt outputs, one per line. Or they can be cascaded into a wider interrupt status vector, merged with the chip's internal interrupt sources at a fixed bit offset.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset every line is masked and in active-low level mode, so every request output is 0. Word 0 reads back 0x000F0000 and word 1 reads back 0x00030000.
- R2: With level-sense 0, any-edge 0 and polarity 1 (rising mode), a 0-to-1 pin transition sets the line's event, and a 1-to-0 transition does not.
- R3: With level-sense 0, any-edge 0 and polarity 0 (falling mode), a 1-to-0 transition sets the event, and a 0-to-1 transition does not.
- R4: With level-sense 0 and any-edge 1, every pin transition sets the event, whatever the polarity.
- R5: With level-sense 1, the request follows the synchronised pin. It is active at pin high when polarity is 1 and at pin low when polarity is 0.
- R6: A line's request is 1 only while its enable bit (control bit 8+slot) is 1. With the enable bit at 0 the request is 0.
- R7: Writing 1 to ack bit `slot` (bits 3:0) of a line's word clears that line's latched edge event. Other lines keep their events, and a 0 in an ack bit changes nothing.
- R8: In level mode an ack write has no effect on the request.
- R9: A latched edge event stays set after the pin returns to its earlier value, until it is acknowledged.
- R10: Control word layout per slot s: enable at bit 8+s, level-sense at 16+s, polarity at 20+s, any-edge at 24+s. Ack bits, reserved bits and bits of unused slots read back as 0.
- R11: With CASCADE=0 the requests appear on `irq_line` and `casc_vec` carries `int_irq` delayed by one clock. With CASCADE=1 `irq_line` stays 0 and request i is ORed into `casc_vec` bit CASC_BASE+i.
- R12: A pin value present at clock edge k is reflected on the request outputs just after edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | NUM_LINES | Asynchronous external interrupt pins |
| int_irq | input | STAT_W | Internal interrupt sources for the status vector |
| reg_we | input | 1 | Control word write strobe |
| reg_re | input | 1 | Control word read strobe |
| reg_addr | input | AW | Control word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_re |
| irq_line | output | NUM_LINES | Per-line requests (zero when cascaded) |
| casc_vec | output | STAT_W | Interrupt status vector |

## Verification
The hardest thing to reach from the ports is the moment when an ack write meets a latched event, while events on other lines stay pending. For this, the bench first latches several lines in different edge modes. It then acknowledges exactly one slot, and next writes a word whose ack bits are all zero. A behavioural model predicts every request on every clock. Explicit checks then pin down the three-edge latency, the readback masking of the unused slots of word 1, and the fact that an ack has no effect in level mode.

// File: rtl/eitu_pkg.sv
package eitu_pkg;
  localparam int LINES_PER_BANK = 4;
  localparam int ACK_LSB = 0;
  localparam int EN_LSB  = 8;
  localparam int LVL_LSB = 16;
  localparam int POL_LSB = 20;
  localparam int ANY_LSB = 24;

  typedef struct packed {
    logic en;   // request enable
    logic lvl;  // level-sense
    logic pol;  // 1: high / rising
    logic any;  // any-edge
  } line_cfg_t;

  localparam line_cfg_t CFG_RESET = '{en: 1'b0, lvl: 1'b1, pol: 1'b0, any: 1'b0};
endpackage

// File: rtl/eitu_sync.sv
module eitu_sync #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] cur,
  output logic [N-1:0] old
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign cur = sync_q;
  assign old = prev_q;
endmodule

// File: rtl/eitu_regs.sv
module eitu_regs
  import eitu_pkg::*;
#(
  parameter int NUM_LINES = 6,
  parameter int AW        = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_we,
  input  logic                        reg_re,
  input  logic [AW-1:0]               reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output line_cfg_t [NUM_LINES-1:0]   cfg,
  output logic [NUM_LINES-1:0]        ack
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int BANK = i / LINES_PER_BANK;
    localparam int SLOT = i % LINES_PER_BANK;
    logic      hit;
    line_cfg_t cfg_q;

    assign hit = reg_we && (int'(reg_addr) == BANK);

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q <= CFG_RESET;
      end else if (hit) begin
        cfg_q <= '{en:  reg_wdata[EN_LSB + SLOT],
                   lvl: reg_wdata[LVL_LSB + SLOT],
                   pol: reg_wdata[POL_LSB + SLOT],
                   any: reg_wdata[ANY_LSB + SLOT]};
      end
    end

    assign cfg[i] = cfg_q;
    assign ack[i] = hit & reg_wdata[ACK_LSB + SLOT];
  end

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if ((i / LINES_PER_BANK) == int'(reg_addr)) begin
        rd_word[EN_LSB  + i % LINES_PER_BANK] = cfg[i].en;
        rd_word[LVL_LSB + i % LINES_PER_BANK] = cfg[i].lvl;
        rd_word[POL_LSB + i % LINES_PER_BANK] = cfg[i].pol;
        rd_word[ANY_LSB + i % LINES_PER_BANK] = cfg[i].any;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_word;
  end
endmodule

// File: rtl/eitu_line.sv
module eitu_line
  import eitu_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cur,
  input  logic      old,
  input  line_cfg_t cfg,
  input  logic      ack,
  output logic      ev,
  output logic      latch_q,
  output logic      req_q
);
  logic rise, fall, active, latch_d;

  assign rise   = cur & ~old;
  assign fall   = ~cur & old;
  assign active = cfg.pol ? cur : ~cur;

  always_comb begin
    if (cfg.lvl)      ev = 1'b0;
    else if (cfg.any) ev = rise | fall;
    else if (cfg.pol) ev = rise;
    else              ev = fall;
  end

  // a new event in the same cycle as an ack wins, so it is not lost
  assign latch_d = cfg.lvl ? 1'b0 : (ev | (latch_q & ~ack));

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      req_q   <= cfg.en & (cfg.lvl ? active : latch_d);
    end
  end
endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger
  import eitu_pkg::*;
#(
  parameter int NUM_LINES = 6,
  parameter int STAT_W    = 32,
  parameter int CASC_BASE = 24,
  parameter int CASCADE   = 0,
  localparam int NBANK    = (NUM_LINES + LINES_PER_BANK - 1) / LINES_PER_BANK,
  localparam int AW       = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] ext_pin,
  input  logic [STAT_W-1:0]    int_irq,
  input  logic                 reg_we,
  input  logic                 reg_re,
  input  logic [AW-1:0]        reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_LINES-1:0] irq_line,
  output logic [STAT_W-1:0]    casc_vec
);
  logic [NUM_LINES-1:0]      cur, old, ack_vec, ev_vec, latch_vec, req_vec;
  logic [NUM_LINES-1:0]      en_vec, lvl_vec;
  line_cfg_t [NUM_LINES-1:0] cfg;
  logic [STAT_W-1:0]         int_q;

  eitu_sync #(.N(NUM_LINES)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_pin), .cur(cur), .old(old)
  );

  eitu_regs #(.NUM_LINES(NUM_LINES), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg(cfg), .ack(ack_vec)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    eitu_line u_line (
      .clk(clk), .rst(rst), .cur(cur[i]), .old(old[i]), .cfg(cfg[i]),
      .ack(ack_vec[i]), .ev(ev_vec[i]), .latch_q(latch_vec[i]),
      .req_q(req_vec[i])
    );
    assign en_vec[i]  = cfg[i].en;
    assign lvl_vec[i] = cfg[i].lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) int_q <= '0;
    else     int_q <= int_irq;
  end

  if (CASCADE != 0) begin : g_casc
    assign irq_line = '0;
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      if (b >= CASC_BASE && b < CASC_BASE + NUM_LINES) begin : g_mix
        assign casc_vec[b] = int_q[b] | req_vec[b - CASC_BASE];
      end else begin : g_pass
        assign casc_vec[b] = int_q[b];
      end
    end
  end else begin : g_direct
    assign irq_line = req_vec;
    assign casc_vec = int_q;
  end
endmodule

// File: rtl/ext_irq_trigger_chk.sv
module ext_irq_trigger_chk #(
  parameter int NUM_LINES = 6,
  parameter int CASCADE   = 0
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] irq_line,
  input logic [31:0]          reg_rdata,
  input logic [NUM_LINES-1:0] en_vec,
  input logic [NUM_LINES-1:0] lvl_vec,
  input logic [NUM_LINES-1:0] ack_vec,
  input logic [NUM_LINES-1:0] ev_vec,
  input logic [NUM_LINES-1:0] latch_vec
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R6: a request needs the enable bit one cycle earlier
  a_r6_req_needs_enable: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((irq_line & ~$past(en_vec)) == '0));

  // R11: cascaded build keeps the direct lines quiet
  a_r11_direct_quiet: assert property (@(posedge clk) disable iff (rst)
    (CASCADE != 0) |-> (irq_line == '0));

  // R10: ack and reserved bits read back as zero
  a_r10_ack_reads_zero: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (reg_rdata[7:0] == 8'h00 && reg_rdata[31:28] == 4'h0));

  // R9: an edge event stays latched without an ack
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (($past(latch_vec & ~lvl_vec & ~ack_vec) & ~latch_vec) == '0));

  // R7: an ack with no simultaneous event removes the latched event
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (($past(ack_vec & ~ev_vec) & latch_vec) == '0));

  // R8: no latched event survives in level mode
  a_r8_level_no_latch: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (($past(lvl_vec) & latch_vec) == '0));
endmodule

bind ext_irq_trigger ext_irq_trigger_chk #(.NUM_LINES(NUM_LINES), .CASCADE(CASCADE)) u_chk (
  .clk(clk), .rst(rst), .irq_line(irq_line), .reg_rdata(reg_rdata),
  .en_vec(en_vec), .lvl_vec(lvl_vec), .ack_vec(ack_vec), .ev_vec(ev_vec),
  .latch_vec(latch_vec)
);

// File: tb/tb_ext_irq_trigger.sv
module tb_ext_irq_trigger;
  localparam int NL = 6;
  localparam int SW = 32;
  localparam int CB = 24;
  localparam logic [31:0] CFG0 = 32'h0821_0F00; // l0 low-level, l1 rise, l2 fall, l3 any, all enabled

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] ext_pin = '0;
  logic [SW-1:0] int_irq = '0;
  logic          reg_we = 1'b0, reg_re = 1'b0;
  logic [0:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   rdata_d, rdata_c;
  logic [NL-1:0] irq_d, irq_c;
  logic [SW-1:0] casc_d, casc_c;

  int errors = 0, checks = 0;
  bit chk_en = 0, done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  ext_irq_trigger #(.NUM_LINES(NL), .STAT_W(SW), .CASC_BASE(CB), .CASCADE(0)) dut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .int_irq(int_irq), .reg_we(reg_we),
    .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_d), .irq_line(irq_d), .casc_vec(casc_d));

  ext_irq_trigger #(.NUM_LINES(NL), .STAT_W(SW), .CASC_BASE(CB), .CASCADE(1)) dut_c (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .int_irq(int_irq), .reg_we(reg_we),
    .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_c), .irq_line(irq_c), .casc_vec(casc_c));

  // behavioural reference: pin history, sticky events, configuration
  bit h1 [NL], h2 [NL], h3 [NL], ev_m [NL], rq_m [NL];
  bit en_m [NL], lvl_m [NL], pol_m [NL], any_m [NL];
  logic [SW-1:0] iq_m;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) begin
        h1[i] = 0; h2[i] = 0; h3[i] = 0; ev_m[i] = 0; rq_m[i] = 0;
        en_m[i] = 0; lvl_m[i] = 1; pol_m[i] = 0; any_m[i] = 0;
      end
      iq_m = '0;
    end else begin
      for (int i = 0; i < NL; i++) begin
        bit hit, edge_seen, act, nxt;
        hit = reg_we && (int'(reg_addr) == i / 4);
        if (any_m[i])      edge_seen = (h2[i] != h3[i]);
        else if (pol_m[i]) edge_seen = h2[i] && !h3[i];
        else               edge_seen = !h2[i] && h3[i];
        act = pol_m[i] ? h2[i] : !h2[i];
        if (lvl_m[i]) nxt = 0;
        else nxt = edge_seen || (ev_m[i] && !(hit && reg_wdata[i % 4]));
        ev_m[i] = nxt;
        rq_m[i] = en_m[i] && (lvl_m[i] ? act : nxt);
        h3[i] = h2[i]; h2[i] = h1[i]; h1[i] = ext_pin[i];
        if (hit) begin
          en_m[i]  = reg_wdata[8 + i % 4];
          lvl_m[i] = reg_wdata[16 + i % 4];
          pol_m[i] = reg_wdata[20 + i % 4];
          any_m[i] = reg_wdata[24 + i % 4];
        end
      end
      iq_m = int_irq;
    end
  end

  function automatic logic [NL-1:0] exp_req();
    logic [NL-1:0] v;
    for (int i = 0; i < NL; i++) v[i] = rq_m[i];
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (chk_en) begin
      logic [NL-1:0] e;
      logic [SW-1:0] pl;
      e = exp_req();
      pl = '0;
      pl[CB +: NL] = e;
      check(cur_req, 32'(irq_d), 32'(e));
      check("R11", casc_d, iq_m);
      check("R11", 32'(irq_c), 32'h0);
      check("R11", casc_c, iq_m | pl);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int bank, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 1'(bank); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input string req, input int bank, input logic [31:0] exp);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = 1'(bank);
    @(negedge clk);
    reg_re = 1'b0;
    check(req, rdata_d, exp);
  endtask

  task automatic pin(input int i, input bit v);
    @(negedge clk);
    ext_pin[i] = v;
    idle(4);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    chk_en = 1;
    // R1: reset state
    cur_req = "R1";
    idle(4);
    check("R1", 32'(irq_d), 32'h0);
    rd("R1", 0, 32'h000F_0000);
    rd("R1", 1, 32'h0003_0000);

    // R6: enable line 0 in active-low level mode, pin low
    cur_req = "R6";
    wr(0, 32'h000F_0100);
    idle(4);
    check("R6", 32'(irq_d[0]), 1);
    check("R6", 32'(irq_d[1]), 0);
    cur_req = "R5";
    pin(0, 1);
    check("R5", 32'(irq_d[0]), 0);

    // mixed edge modes on word 0
    wr(0, CFG0);
    rd("R10", 0, CFG0);
    idle(4);
    cur_req = "R2";
    pin(1, 1);
    check("R2", 32'(irq_d[1]), 1);
    cur_req = "R9";
    pin(1, 0);
    check("R9", 32'(irq_d[1]), 1);
    cur_req = "R3";
    pin(2, 1);
    check("R3", 32'(irq_d[2]), 0);
    pin(2, 0);
    check("R3", 32'(irq_d[2]), 1);
    cur_req = "R4";
    pin(3, 1);
    check("R4", 32'(irq_d[3]), 1);

    // R7: ack one slot only
    cur_req = "R7";
    wr(0, CFG0 | 32'h8);
    idle(2);
    check("R7", 32'(irq_d[3:1]), 32'b011);
    cur_req = "R4";
    pin(3, 0);
    check("R4", 32'(irq_d[3]), 1);
    cur_req = "R7";
    wr(0, CFG0 | 32'h2);
    idle(2);
    check("R7", 32'(irq_d[3:1]), 32'b110);
    wr(0, CFG0);
    idle(2);
    check("R7", 32'(irq_d[3:1]), 32'b110);

    // R8: ack on a level-mode line
    cur_req = "R8";
    pin(0, 0);
    check("R8", 32'(irq_d[0]), 1);
    wr(0, CFG0 | 32'h1);
    idle(3);
    check("R8", 32'(irq_d[0]), 1);

    // R12: latency of a pin change to the request
    cur_req = "R12";
    @(negedge clk);
    ext_pin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R12", 32'(irq_d[0]), 1);
    @(negedge clk);
    check("R12", 32'(irq_d[0]), 0);

    // R10: word 1 with junk in unused slots and reserved bits
    cur_req = "R10";
    wr(1, 32'hF03E_0FFC);
    rd("R10", 1, 32'h0032_0300);
    cur_req = "R5";
    pin(5, 1);
    check("R5", 32'(irq_d[5]), 1);
    pin(5, 0);
    check("R5", 32'(irq_d[5]), 0);
    cur_req = "R2";
    pin(4, 1);
    check("R2", 32'(irq_d[4]), 1);
    check("R11", 32'(casc_c[CB + 4]), 1);

    // R11: internal sources merged into the status vector
    cur_req = "R11";
    @(negedge clk);
    int_irq = 32'h00A5_0003;
    idle(2);
    check("R11", casc_d, 32'h00A5_0003);
    check("R11", 32'(casc_c[23:0]), 32'hA5_0003);

    // R12: pseudo-random pins compared against the model every cycle
    cur_req = "R12";
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[0]) ext_pin = lfsr[NL:1];
        int_irq = {lfsr, lfsr};
        if ((n % 97) == 0) begin
          reg_we = 1'b1; reg_addr = 1'(n % 2);
          reg_wdata = (n % 2 == 0) ? (CFG0 | {28'h0, lfsr[3:0]}) : 32'h0032_0303;
        end else begin
          reg_we = 1'b0;
        end
      end
      @(negedge clk);
      reg_we = 1'b0;
    end
    idle(4);
    done = 1;
    summary();
  end
endmodule